// File: doc/BRIEF.md
# Grouped Interrupt Controller with Per-Source Polarity

This block takes sixty-four raw interrupt inputs, split into four groups of sixteen: local bus, LPC, PCI/device and NMI. Every source can be set to level or edge sensitivity and to high or low activity. Each input first passes through a two-flop synchronizer. A level source is pending while its conditioned input is active. An edge source latches a pending bit on its active edge, and that bit stays set until software clears it.

Each group has a mask, a trigger-mode register, a polarity register and a request register, all 16 bits wide. A request register reads back the pending bits that the mask does not block. A 4-bit summary shows which groups have an unmasked request. The CPU interrupt line covers the first three groups, and a separate NMI line covers the fourth. Software reaches the registers through a simple synchronous port: writes take effect on the clock edge, and reads are combinational from the address.

Top module: `grp_intc`

## Requirements
- R1: After reset, every mask register reads 0xFFFF and every trigger and polarity register reads 0. The address decodes as follows: addr[4]=1 selects the summary. Otherwise addr[3:2] selects the register kind (0 mask, 1 trigger, 2 polarity, 3 request) and addr[1:0] selects the group (0 local bus, 1 LPC, 2 PCI, 3 NMI). Source n of group g is src_i[16g+n].
- R2: A mask bit of 1 blocks its source from the request readback, the summary and both outputs. A mask bit of 0 lets the source through.
- R3: With trigger bit 0 and polarity bit 1, the request bit follows the input and is active while the input is high. It becomes visible two clock edges after the input changes.
- R4: With trigger bit 0 and polarity bit 0, the source is pending while the input is low.
- R5: With trigger bit 1 and polarity bit 1, a rising input edge latches the request bit on the third clock edge after the change. The bit stays set after the input falls.
- R6: With trigger bit 1 and polarity bit 0, a falling edge latches the request bit and a rising edge does not.
- R7: Writing a request register clears each latched bit whose written value is 1 and leaves the other latched bits unchanged.
- R8: Writing 0x0000 to the LPC request register clears all latched LPC bits. Writing 0x0000 to any other group's request register changes nothing.
- R9: Summary bit g (bits 0 local bus, 1 LPC, 2 PCI, 3 NMI) is the OR of the unmasked request bits of group g.
- R10: irq_o is the OR of summary bits 0 to 2. nmi_o equals summary bit 3, and NMI requests never drive irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Raw interrupt inputs, group g source n at bit 16g+n |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| irq_o | output | 1 | CPU interrupt request |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
An input change reaches a level request after two clock edges because of the synchronizer. It reaches an edge latch after three edges, since the edge compare adds one more register. A register write or a request clear shows on the read port right after its write edge, because reads and outputs are combinational. The scoreboard samples on the falling clock edge: it reads one cycle and two cycles after an input change to bound the level latency, and three cycles after the change to bound the edge latency. All other checks wait long enough for the input to settle before reading.

// File: rtl/grp_intc.sv
module grp_intc #(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4*W-1:0]  src_i,
  input  logic            wr_en,
  input  logic [4:0]      addr,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    rdata,
  output logic            irq_o,
  output logic            nmi_o
);
  localparam int NG    = 4;
  localparam int N     = NG * W;
  localparam int LPC_G = 1;
  localparam int NMI_G = NG - 1;
  localparam int IRQ_N = NMI_G * W;

  logic [N-1:0]  mask_q, trig_q, pol_q, lat_q;
  logic [N-1:0]  s1_q, s2_q, s2p_q;
  logic [N-1:0]  cond, rise, fall, edg, clr, pend, act;
  logic [NG-1:0] summary;
  logic [1:0]    kind, grp;

  assign kind = addr[3:2];
  assign grp  = addr[1:0];

  assign cond = ~(s2_q ^ pol_q);
  assign rise = s2_q & ~s2p_q;
  assign fall = ~s2_q & s2p_q;
  assign edg  = trig_q & ((pol_q & rise) | (~pol_q & fall));
  assign pend = (trig_q & lat_q) | (~trig_q & cond);
  assign act  = pend & ~mask_q;

  always_comb begin
    clr = '0;
    if (wr_en && !addr[4] && kind == 2'd3) begin
      clr[int'(grp)*W +: W] = wdata;
      if (int'(grp) == LPC_G && wdata == '0)
        clr[LPC_G*W +: W] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      s2p_q <= '0;
      lat_q <= '0;
    end else begin
      s1_q  <= src_i;
      s2_q  <= s1_q;
      s2p_q <= s2_q;
      lat_q <= (lat_q & ~clr) | edg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
      pol_q  <= '0;
    end else if (wr_en && !addr[4]) begin
      case (kind)
        2'd0: mask_q[int'(grp)*W +: W] <= wdata;
        2'd1: trig_q[int'(grp)*W +: W] <= wdata;
        2'd2: pol_q[int'(grp)*W +: W]  <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_sum
    assign summary[g] = |act[g*W +: W];
  end

  assign irq_o = |summary[NMI_G-1:0];
  assign nmi_o = summary[NMI_G];

  always_comb begin
    rdata = '0;
    if (addr[4]) rdata[NG-1:0] = summary;
    else begin
      case (kind)
        2'd0:    rdata = mask_q[int'(grp)*W +: W];
        2'd1:    rdata = trig_q[int'(grp)*W +: W];
        2'd2:    rdata = pol_q[int'(grp)*W +: W];
        default: rdata = act[int'(grp)*W +: W];
      endcase
    end
  end

  // R5 R6: a latched edge request holds until explicitly cleared
  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat_q) & ~$past(clr) & ~lat_q) == '0));

  // R6: latched bits appear only where a qualifying edge was seen
  p_latch_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(edg)) == '0));

  // R8: a zero write to the LPC request register empties its latches
  p_lpc_zero_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd13 && wdata == '0)
      |=> ((lat_q[LPC_G*W +: W] & ~$past(edg[LPC_G*W +: W])) == '0));

  // R2 R10: fully masked groups cannot raise the outputs
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[IRQ_N-1:0]) |-> !irq_o);

  p_nmi_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[NMI_G*W +: W]) |-> !nmi_o);
endmodule

// File: tb/sim_grp_intc.sv
`timescale 1ns/1ps
module sim_grp_intc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] src = '0;
  logic        wr_en = 0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o, nmi_o;

  typedef struct {
    logic [15:0] rd;
    logic        irq;
    logic        nmi;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_intc u0 (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en),
               .addr(addr), .wdata(wdata), .rdata(rdata),
               .irq_o(irq_o), .nmi_o(nmi_o));

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdata !== it.rd || irq_o !== it.irq || nmi_o !== it.nmi) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b nmi=%b expected rdata=%h irq=%b nmi=%b",
                 it.tag, rdata, irq_o, nmi_o, it.rd, it.irq, it.nmi);
      end
    end
  end

  task automatic chk(input logic [4:0] a, input logic [15:0] e,
                     input logic ei, input logic en, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.rd = e; it.irq = ei; it.nmi = en; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #0.2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic setsrc(input int i, input logic v);
    @(posedge clk); #1;
    src[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    #1 rst_n = 1;
    // R1 reset state
    chk(5'd0,  16'hFFFF, 0, 0, "R1 mask lb");
    chk(5'd3,  16'hFFFF, 0, 0, "R1 mask nmi");
    chk(5'd5,  16'h0000, 0, 0, "R1 trig lpc");
    chk(5'd10, 16'h0000, 0, 0, "R1 pol pci");
    chk(5'd12, 16'h0000, 0, 0, "R1 req lb masked");
    chk(5'd16, 16'h0000, 0, 0, "R1 summary");
    // R3 level active high on PCI source 3
    wr(5'd10, 16'h0008);
    wr(5'd2,  16'hFFF7);
    chk(5'd14, 16'h0000, 0, 0, "R3 idle low");
    setsrc(35, 1);
    chk(5'd14, 16'h0000, 0, 0, "R3 one edge after change");
    chk(5'd14, 16'h0008, 1, 0, "R3 two edges after change");
    chk(5'd16, 16'h0004, 1, 0, "R9 summary pci");
    wr(5'd2, 16'hFFFF);
    chk(5'd14, 16'h0000, 0, 0, "R2 masked pci req");
    chk(5'd16, 16'h0000, 0, 0, "R2 masked summary");
    wr(5'd2, 16'hFFF7);
    chk(5'd14, 16'h0008, 1, 0, "R2 unmask again");
    setsrc(35, 0);
    idle(4);
    chk(5'd14, 16'h0000, 0, 0, "R3 follows low");
    // R4 level active low on local bus source 5
    wr(5'd0, 16'hFFDF);
    chk(5'd12, 16'h0020, 1, 0, "R4 low input active");
    chk(5'd16, 16'h0001, 1, 0, "R9 summary lb");
    setsrc(5, 1);
    idle(4);
    chk(5'd12, 16'h0000, 0, 0, "R4 high input inactive");
    // R5 rising edge on LPC source 2
    wr(5'd5, 16'h0004);
    wr(5'd9, 16'h0004);
    wr(5'd1, 16'hFFFB);
    chk(5'd13, 16'h0000, 0, 0, "R5 before edge");
    setsrc(18, 1);
    chk(5'd13, 16'h0000, 0, 0, "R5 edge +1");
    chk(5'd13, 16'h0000, 0, 0, "R5 edge +2");
    chk(5'd13, 16'h0004, 1, 0, "R5 edge +3 latched");
    setsrc(18, 0);
    idle(4);
    chk(5'd13, 16'h0004, 1, 0, "R5 held after fall");
    chk(5'd16, 16'h0002, 1, 0, "R9 summary lpc");
    // R8 zero write clears LPC
    wr(5'd13, 16'h0000);
    chk(5'd13, 16'h0000, 0, 0, "R8 lpc zero clear");
    // R6 falling edge on LPC source 7
    wr(5'd5, 16'h0084);
    wr(5'd1, 16'hFF7B);
    setsrc(23, 1);
    idle(4);
    chk(5'd13, 16'h0000, 0, 0, "R6 rising ignored");
    setsrc(23, 0);
    idle(4);
    chk(5'd13, 16'h0080, 1, 0, "R6 falling latched");
    // R7 selective clear
    setsrc(18, 1);
    idle(4);
    setsrc(18, 0);
    idle(4);
    chk(5'd13, 16'h0084, 1, 0, "R7 two latched");
    wr(5'd13, 16'h0080);
    chk(5'd13, 16'h0004, 1, 0, "R7 clear bit 7 only");
    wr(5'd13, 16'h0000);
    chk(5'd13, 16'h0000, 0, 0, "R8 lpc zero clear again");
    // R10 NMI group, edge active high on source 0
    wr(5'd7,  16'h0001);
    wr(5'd11, 16'h0001);
    wr(5'd3,  16'hFFFE);
    setsrc(48, 1);
    idle(4);
    setsrc(48, 0);
    idle(4);
    chk(5'd15, 16'h0001, 0, 1, "R10 nmi only");
    chk(5'd16, 16'h0008, 0, 1, "R9 summary nmi");
    wr(5'd15, 16'h0000);
    chk(5'd15, 16'h0001, 0, 1, "R8 zero write ignored on nmi");
    wr(5'd15, 16'h0001);
    chk(5'd15, 16'h0000, 0, 0, "R7 nmi clear");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule